// File: doc/BRIEF.md
# Power Switchover Timestamp Capture

This block records the calendar time at the moments the chip's supply moves between the main rail and the backup battery. A power switch outside the block provides a level that is high while the chip runs from the battery. The clock core provides the current time and date as a packed BCD bus. The host can read two timestamp sets. The power-down set records a main-to-battery change. The power-up set records a battery-to-main change.

The two sets treat repeated events differently. Once the power-down set holds a value, it is occupied and keeps that value. Later outages cannot overwrite it. This lets software find when the first outage began. The power-up set takes the time on every return to main power, so it always shows the most recent recovery. A one-cycle clear command from the register interface empties both sets and re-arms the power-down capture. The host cannot reach the block while the chip runs from the battery, so clears only arrive on main power.

The supply level is asynchronous to the block clock. It passes through a synchronizer and an edge detector before it can trigger a capture.

Top module: `pwr_event_stamp`

## Requirements
- R1: After reset, both timestamp buses read all zeros and both occupied flags are low.
- R2: A low-to-high change of `on_backup_i` stores `now_i` into the power-down set and raises `dn_valid_o`. The value stored is the one sampled at the third rising clock edge after the change. The stored value appears at the output after that edge and not before it.
- R3: A high-to-low change of `on_backup_i` stores `now_i` into the power-up set and raises `up_valid_o`. It has the same three-edge timing as R2.
- R4: While `dn_valid_o` is high, a further power-down change leaves the power-down set unchanged.
- R5: Every power-up change overwrites the power-up set, including when it already holds a value.
- R6: A `clear_i` pulse sets both sets to zero and drops both flags at the next edge. After that, the next power-down change is captured again.
- R7: When a clear and a capture reach the same set on the same edge, the clear is applied first. The capture is then stored and its flag is raised.
- R8: While `on_backup_i` is held steady, changes on `now_i` leave both sets and both flags unchanged.
- R9: The time bus is six BCD bytes. Bits [7:0] hold seconds, [15:8] minutes, [23:16] hours, [31:24] date, [39:32] month and [47:40] year. Each set stores the whole bus unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; the supply is assumed to be on main power at reset |
| on_backup_i | input | 1 | Asynchronous supply level, 1 = running from battery |
| now_i | input | FIELDS*FIELD_W (48) | Current BCD time and date from the clock core |
| clear_i | input | 1 | One-cycle clear of both timestamp sets |
| dn_stamp_o | output | FIELDS*FIELD_W (48) | Power-down timestamp (main to battery) |
| dn_valid_o | output | 1 | Power-down set occupied |
| up_stamp_o | output | FIELDS*FIELD_W (48) | Power-up timestamp (battery to main) |
| up_valid_o | output | 1 | Power-up set holds a capture |

## Verification
The assertions assume that `clear_i` is never high while the synchronized supply level shows battery operation, which matches the bus being unavailable in backup mode. The latency checks assume the synchronizer uses its default two stages. The bench raises a clear only after the supply has been back on main power long enough for the synchronizer to settle. The only same-edge collision it drives is a clear together with a power-up capture. It holds `now_i` constant across each three-edge capture window, so the expected stamp is known exactly.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

    // Retention policy of one timestamp set.
    typedef enum logic {
        KEEP_OLDEST = 1'b0,  // first capture sticks until cleared
        KEEP_NEWEST = 1'b1   // every capture overwrites
    } keep_policy_e;

    function automatic int unsigned stamp_bits(input int unsigned fields,
                                               input int unsigned field_w);
        return fields * field_w;
    endfunction

endpackage

// File: rtl/supply_edge_sync.sv
module supply_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [MSB:0] chain;
        logic         last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[MSB-1:0], async_i};
        st_d.last  = st_q.chain[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.chain[MSB];
    assign rise_o  =  st_q.chain[MSB] & ~st_q.last;
    assign fall_o  = ~st_q.chain[MSB] &  st_q.last;

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            // R2: a rise reflects the raw level seen two edges earlier
            p_rise_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o |-> $past(async_i, 2));
            // R3: a fall reflects the raw level seen two edges earlier
            p_fall_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
                fall_o |-> !$past(async_i, 2));
        end
    endgenerate

endmodule

// File: rtl/stamp_bank.sv
module stamp_bank
    import stamp_pkg::*;
#(
    parameter int unsigned  STAMP_W = 48,
    parameter keep_policy_e POLICY  = KEEP_NEWEST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               event_i,
    input  logic               clear_i,
    input  logic [STAMP_W-1:0] time_i,
    output logic [STAMP_W-1:0] stamp_o,
    output logic               valid_o
);

    typedef struct packed {
        logic               valid;
        logic [STAMP_W-1:0] stamp;
    } bank_state_t;

    bank_state_t st_d, st_q;
    bank_state_t base;   // state after the clear has been applied
    logic        take;

    always_comb begin
        base = st_q;
        if (clear_i) begin
            base.valid = 1'b0;
            base.stamp = '0;
        end
    end

    generate
        if (POLICY == KEEP_OLDEST) begin : g_oldest
            assign take = event_i & ~base.valid;
        end else begin : g_newest
            assign take = event_i;
        end
    endgenerate

    always_comb begin
        st_d = base;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.stamp = time_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stamp_o = st_q.stamp;
    assign valid_o = st_q.valid;

    // R2 / R3: any event leaves the set occupied
    p_capture_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> valid_o);

    // R6: a clear with no event empties the set
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !event_i) |=> (!valid_o && stamp_o == '0));

    // R7: clear first, then capture the presented time
    p_clear_then_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && event_i) |=> (valid_o && stamp_o == $past(time_i)));

    // R8: with no event and no clear nothing moves
    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!event_i && !clear_i) |=> ($stable(stamp_o) && $stable(valid_o)));

    generate
        if (POLICY == KEEP_OLDEST) begin : g_chk_oldest
            // R4: an occupied set keeps its first capture
            p_oldest_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_o && !clear_i) |=> $stable(stamp_o));
        end else begin : g_chk_newest
            // R5: every event overwrites
            p_newest_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
                event_i |=> (stamp_o == $past(time_i)));
        end
    endgenerate

endmodule

// File: rtl/pwr_event_stamp.sv
module pwr_event_stamp
    import stamp_pkg::*;
#(
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned FIELDS      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       on_backup_i,
    input  logic [FIELDS*FIELD_W-1:0]  now_i,
    input  logic                       clear_i,
    output logic [FIELDS*FIELD_W-1:0]  dn_stamp_o,
    output logic                       dn_valid_o,
    output logic [FIELDS*FIELD_W-1:0]  up_stamp_o,
    output logic                       up_valid_o
);

    localparam int unsigned STAMP_W = stamp_bits(FIELDS, FIELD_W);

    logic sup_level, sup_rise, sup_fall;

    supply_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (on_backup_i),
        .level_o (sup_level),
        .rise_o  (sup_rise),
        .fall_o  (sup_fall)
    );

    stamp_bank #(
        .STAMP_W (STAMP_W),
        .POLICY  (KEEP_OLDEST)
    ) i_dn_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (sup_rise),
        .clear_i (clear_i),
        .time_i  (now_i),
        .stamp_o (dn_stamp_o),
        .valid_o (dn_valid_o)
    );

    stamp_bank #(
        .STAMP_W (STAMP_W),
        .POLICY  (KEEP_NEWEST)
    ) i_up_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (sup_fall),
        .clear_i (clear_i),
        .time_i  (now_i),
        .stamp_o (up_stamp_o),
        .valid_o (up_valid_o)
    );

    // R6 input assumption: the host cannot clear while on battery
    p_clear_on_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sup_level |-> !clear_i);

    // R2: the power-down set only gains a value through a rise
    p_dn_fill_needs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_valid_o && !sup_rise) |=> !dn_valid_o);

endmodule

// File: tb/test_pwr_event_stamp.sv
module test_pwr_event_stamp;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         on_backup = 1'b0;
    logic [W-1:0] now = '0;
    logic         clear = 1'b0;
    logic [W-1:0] dn_stamp, up_stamp;
    logic         dn_valid, up_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_event_stamp i_pwr_event_stamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .on_backup_i (on_backup),
        .now_i       (now),
        .clear_i     (clear),
        .dn_stamp_o  (dn_stamp),
        .dn_valid_o  (dn_valid),
        .up_stamp_o  (up_stamp),
        .up_valid_o  (up_valid)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Change the supply level at a falling edge; return at the falling edge
    // after the third rising edge, when the capture is visible.
    task automatic switch_supply(input logic lvl, input logic [W-1:0] t);
        @(negedge clk);
        now       = t;
        on_backup = lvl;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 dn stamp", dn_stamp, '0);
        check("R1 up stamp", up_stamp, '0);
        check("R1 flags", {46'd0, dn_valid, up_valid}, '0);
    endtask

    task automatic t_first_down();
        @(negedge clk);
        now       = 48'h24_03_11_08_15_30;
        on_backup = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 no early capture", {47'd0, dn_valid}, '0);
        @(negedge clk);
        check("R2 dn stamp", dn_stamp, 48'h24_03_11_08_15_30);
        check("R2 dn valid", {47'd0, dn_valid}, 48'd1);
        check("R9 up untouched", up_stamp, '0);
    endtask

    task automatic t_first_up();
        switch_supply(1'b0, 48'h24_03_11_09_02_07);
        check("R3 up stamp", up_stamp, 48'h24_03_11_09_02_07);
        check("R3 up valid", {47'd0, up_valid}, 48'd1);
        check("R3 dn kept", dn_stamp, 48'h24_03_11_08_15_30);
    endtask

    task automatic t_repeat_cycle();
        switch_supply(1'b1, 48'h24_03_12_23_59_59);
        check("R4 dn keeps first", dn_stamp, 48'h24_03_11_08_15_30);
        switch_supply(1'b0, 48'h24_03_13_00_00_01);
        check("R5 up takes latest", up_stamp, 48'h24_03_13_00_00_01);
    endtask

    task automatic t_steady_main();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            now = 48'h25_12_31_23_59_50 + 48'(i);
        end
        @(negedge clk);
        check("R8 dn steady main", dn_stamp, 48'h24_03_11_08_15_30);
        check("R8 up steady main", up_stamp, 48'h24_03_13_00_00_01);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check("R6 dn cleared", dn_stamp, '0);
        check("R6 up cleared", up_stamp, '0);
        check("R6 flags cleared", {46'd0, dn_valid, up_valid}, '0);
        switch_supply(1'b1, 48'h26_07_04_12_00_00);
        check("R6 rearmed dn", dn_stamp, 48'h26_07_04_12_00_00);
    endtask

    task automatic t_clear_collide();
        @(negedge clk);
        now       = 48'h26_07_04_13_30_45;
        on_backup = 1'b0;
        repeat (2) @(negedge clk);
        clear = 1'b1;          // lands on the same edge as the up capture
        @(negedge clk);
        clear = 1'b0;
        check("R7 up captured", up_stamp, 48'h26_07_04_13_30_45);
        check("R7 up valid", {47'd0, up_valid}, 48'd1);
        check("R7 dn cleared", {dn_stamp[46:0], dn_valid}, '0);
    endtask

    task automatic t_steady_battery();
        switch_supply(1'b1, 48'h27_01_01_00_00_00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            now = 48'h27_02_02_02_02_02 + 48'(i);
        end
        @(negedge clk);
        check("R8 dn steady battery", dn_stamp, 48'h27_01_01_00_00_00);
        check("R8 up steady battery", up_stamp, 48'h26_07_04_13_30_45);
        switch_supply(1'b0, 48'h27_01_01_06_00_00);
        check("R5 up overwritten", up_stamp, 48'h27_01_01_06_00_00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_down();
        t_first_up();
        t_repeat_cycle();
        t_steady_main();
        t_clear();
        t_clear_collide();
        t_steady_battery();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule